// File: doc/BRIEF.md
# Overload Retry Sequencer

This block guards the output stage of one or more supply channels against sustained overcurrent. Each channel watches an overcurrent comparator and, depending on a per-channel mode bit, either runs a timed shutdown-and-retry loop or simply reports the clamp condition. It drives the enable gate of the channel's output stage and an overload flag that a register interface reads back.

In the retry mode, an overload turns the output off for a long window, then turns it back on for a short probe window with the current clamped by the analog stage. A probe window that passes with no overload returns the channel to normal operation. Any overload seen during the probe starts another off window. Both windows are counted in ticks of a shared millisecond timebase, so the default lengths of 900 and 20 ticks give a 920 ms retry period. In the clamp-report mode the output always stays on, and the flag follows the comparator.

Top module: `ovp_seq_top`

## Requirements
- R1: In retry mode (mode bit 0), with the channel enabled and soft-start done, an overcurrent sampled at a clock edge while the channel runs normally drives out_en low and ovl_flag high from that edge on.
- R2: The off window lasts exactly OFF_MS timebase ticks. No tick means no progress, and the overcurrent input is ignored during this window.
- R3: After the off window, out_en returns high for exactly ON_MS ticks, and ovl_flag stays high for the whole probe window.
- R4: An overcurrent sampled at any edge of the probe window, including its last edge, makes the next off window begin when the probe window ends.
- R5: A probe window with no overcurrent sampled returns the channel to normal operation, with out_en high and ovl_flag low.
- R6: In clamp-report mode (mode bit 1), ovl_flag equals the overcurrent input sampled at the previous edge, and out_en stays high.
- R7: While soft-start is not done, ovl_flag is low, out_en is high and overcurrent is ignored.
- R8: With the channel enable low, out_en and ovl_flag are low one edge later and the sequencer returns to normal. Both outputs are low after reset.
- R9: A change of the mode bit forces normal operation (out_en high, ovl_flag low) for one edge, whatever the state. The overcurrent is evaluated again under the new mode from the next edge.
- R10: Channels are independent: activity on one channel does not change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond, shared by all channels |
| ch_en | input | NUM_CH | Per-channel enable |
| oc_det | input | NUM_CH | Per-channel overcurrent comparator output |
| static_mode | input | NUM_CH | Per-channel mode: 0 retry loop, 1 clamp report |
| ss_done | input | NUM_CH | Per-channel soft-start complete |
| out_en | output | NUM_CH | Per-channel output-stage enable gate |
| ovl_flag | output | NUM_CH | Per-channel overload flag |

## Verification
The assertions check on every cycle the rules that need no memory of the window timing: a disabled channel goes dark, clamp-report mode never gates the output and makes the flag follow the comparator, a gated output always carries the flag, and the flag stays low before soft-start ends. The window lengths, the retry decision for an overcurrent at each position in the probe window, the stall without ticks, and the one-edge recovery on a mode change depend on counted sequences. Only the bench scenarios can show them, by measuring how many cycles each window lasts.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_OFF    = 2'd1,
        ST_PROBE  = 2'd2
    } ovp_state_e;

    typedef struct packed {
        ovp_state_e state;
        logic       flag;
        logic       gate;
        logic       seen_oc;
        logic       mode;
    } ovp_regs_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ovp_win_timer.sv
module ovp_win_timer #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] count_d, count_q;
    logic             at_last;

    assign at_last = (count_q == (limit - CNT_W'(1)));
    assign expire  = tick && !clr && at_last;

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (tick) begin
            count_d = at_last ? '0 : (count_q + CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

endmodule

// File: rtl/ovp_chan_seq.sv
module ovp_chan_seq
    import ovp_pkg::*;
#(
    parameter int unsigned OFF_TICKS = 900,
    parameter int unsigned ON_TICKS  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ch_en,
    input  logic oc_det,
    input  logic static_mode,
    input  logic ss_done,
    output logic out_en,
    output logic ovl_flag
);

    localparam int unsigned MAX_TICKS = max_u(OFF_TICKS, ON_TICKS);
    localparam int unsigned CNT_W     = (MAX_TICKS < 2) ? 1 : $clog2(MAX_TICKS);

    ovp_regs_t        cur_q, nxt_d;
    logic             tmr_clr;
    logic             tmr_expire;
    logic [CNT_W-1:0] tmr_limit;
    logic             mode_chg;
    logic             oc_any;

    assign mode_chg  = (static_mode != cur_q.mode);
    assign tmr_limit = (cur_q.state == ST_OFF) ? CNT_W'(OFF_TICKS) : CNT_W'(ON_TICKS);
    assign tmr_clr   = !ch_en || !ss_done || mode_chg || static_mode ||
                       (cur_q.state == ST_NORMAL);
    assign oc_any    = cur_q.seen_oc || oc_det;

    ovp_win_timer #(
        .CNT_W (CNT_W)
    ) win_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick   (tick),
        .limit  (tmr_limit),
        .expire (tmr_expire)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.mode = static_mode;
        if (!ch_en) begin
            nxt_d.state   = ST_NORMAL;
            nxt_d.flag    = 1'b0;
            nxt_d.gate    = 1'b0;
            nxt_d.seen_oc = 1'b0;
        end else if (!ss_done || mode_chg) begin
            nxt_d.state   = ST_NORMAL;
            nxt_d.flag    = 1'b0;
            nxt_d.gate    = 1'b1;
            nxt_d.seen_oc = 1'b0;
        end else if (static_mode) begin
            nxt_d.state   = ST_NORMAL;
            nxt_d.flag    = oc_det;
            nxt_d.gate    = 1'b1;
            nxt_d.seen_oc = 1'b0;
        end else begin
            unique case (cur_q.state)
                ST_NORMAL: begin
                    nxt_d.seen_oc = 1'b0;
                    if (oc_det) begin
                        nxt_d.state = ST_OFF;
                        nxt_d.flag  = 1'b1;
                        nxt_d.gate  = 1'b0;
                    end else begin
                        nxt_d.flag = 1'b0;
                        nxt_d.gate = 1'b1;
                    end
                end
                ST_OFF: begin
                    nxt_d.flag    = 1'b1;
                    nxt_d.gate    = 1'b0;
                    nxt_d.seen_oc = 1'b0;
                    if (tmr_expire) begin
                        nxt_d.state = ST_PROBE;
                        nxt_d.gate  = 1'b1;
                    end
                end
                ST_PROBE: begin
                    nxt_d.flag    = 1'b1;
                    nxt_d.gate    = 1'b1;
                    nxt_d.seen_oc = oc_any;
                    if (tmr_expire) begin
                        nxt_d.seen_oc = 1'b0;
                        if (oc_any) begin
                            nxt_d.state = ST_OFF;
                            nxt_d.gate  = 1'b0;
                        end else begin
                            nxt_d.state = ST_NORMAL;
                            nxt_d.flag  = 1'b0;
                        end
                    end
                end
                default: begin
                    nxt_d.state   = ST_NORMAL;
                    nxt_d.flag    = 1'b0;
                    nxt_d.gate    = 1'b1;
                    nxt_d.seen_oc = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state   <= ST_NORMAL;
            cur_q.flag    <= 1'b0;
            cur_q.gate    <= 1'b0;
            cur_q.seen_oc <= 1'b0;
            cur_q.mode    <= static_mode;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign out_en   = cur_q.gate;
    assign ovl_flag = cur_q.flag;

endmodule

// File: rtl/ovp_seq_top.sv
module ovp_seq_top #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned OFF_MS = 900,
    parameter int unsigned ON_MS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] oc_det,
    input  logic [NUM_CH-1:0] static_mode,
    input  logic [NUM_CH-1:0] ss_done,
    output logic [NUM_CH-1:0] out_en,
    output logic [NUM_CH-1:0] ovl_flag
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ovp_chan_seq #(
            .OFF_TICKS (OFF_MS),
            .ON_TICKS  (ON_MS)
        ) seq_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (ms_tick),
            .ch_en       (ch_en[c]),
            .oc_det      (oc_det[c]),
            .static_mode (static_mode[c]),
            .ss_done     (ss_done[c]),
            .out_en      (out_en[c]),
            .ovl_flag    (ovl_flag[c])
        );
    end

endmodule

// File: rtl/ovp_seq_chk.sv
module ovp_seq_chk #(
    parameter int unsigned NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] oc_det,
    input logic [NUM_CH-1:0] static_mode,
    input logic [NUM_CH-1:0] ss_done,
    input logic [NUM_CH-1:0] out_en,
    input logic [NUM_CH-1:0] ovl_flag
);

    logic past_valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) past_valid_q <= 1'b0;
        else        past_valid_q <= 1'b1;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R8: disabled channel goes dark one edge later
        p_disable_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
            past_valid_q && !ch_en[c] |=> !out_en[c] && !ovl_flag[c]);

        // R6: clamp-report mode never gates the output
        p_static_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            past_valid_q && ch_en[c] && static_mode[c] |=> out_en[c]);

        // R6: clamp-report flag follows the comparator
        p_static_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            past_valid_q && ch_en[c] && ss_done[c] && static_mode[c] && $stable(static_mode[c])
            |=> ovl_flag[c] == $past(oc_det[c]));

        // R1: an enabled channel with its output gated always reports overload
        p_gated_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
            past_valid_q && $past(ch_en[c]) && !out_en[c] |-> ovl_flag[c]);

        // R7: flag low while soft-start was not done at the last edge
        p_softstart_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            past_valid_q && !$past(ss_done[c]) |-> !ovl_flag[c]);
    end

endmodule

bind ovp_seq_top ovp_seq_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_en       (ch_en),
    .oc_det      (oc_det),
    .static_mode (static_mode),
    .ss_done     (ss_done),
    .out_en      (out_en),
    .ovl_flag    (ovl_flag)
);

// File: tb/ovp_seq_top_tb.sv
`timescale 1ns/1ps
module ovp_seq_top_tb_top;

    localparam int NCH  = 2;
    localparam int OFFN = 6;
    localparam int ONN  = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           ms_tick;
    logic [NCH-1:0] ch_en, oc_det, static_mode, ss_done;
    logic [NCH-1:0] out_en, ovl_flag;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    ovp_seq_top #(.NUM_CH(NCH), .OFF_MS(OFFN), .ON_MS(ONN)) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ch_en(ch_en),
        .oc_det(oc_det), .static_mode(static_mode), .ss_done(ss_done),
        .out_en(out_en), .ovl_flag(ovl_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Count negedges with channel 0 gated off, starting at the current one.
    task automatic count_off(output int n);
        n = 0;
        while (!out_en[0] && n < 200) begin
            n++;
            step();
        end
    endtask

    // Count probe-window negedges; pulse overcurrent at index p (p<0: none).
    task automatic count_on(input int p, output int n);
        n = 0;
        while (out_en[0] && ovl_flag[0] && n < 200) begin
            oc_det[0] = (n == p);
            n++;
            step();
        end
        oc_det[0] = 1'b0;
    endtask

    task automatic trigger0();
        oc_det[0] = 1'b1;
        step();
        check("R1 gate after overload", out_en[0], 0);
        check("R1 flag after overload", ovl_flag[0], 1);
        check("R10 other channel gate", out_en[1], 1);
        oc_det[0] = 1'b0;
    endtask

    initial begin
        int n;
        int hi;
        int exp_flag;
        rst_n = 0; ms_tick = 1; ch_en = '0; oc_det = '0; static_mode = '0; ss_done = '0;
        repeat (3) step();
        rst_n = 1;
        step();
        check("R8 reset gate", out_en, 0);
        check("R8 reset flag", ovl_flag, 0);

        // R7: soft-start in progress, overcurrent ignored
        ch_en = '1; oc_det = '1;
        repeat (3) step();
        check("R7 gate during soft-start", out_en, 3);
        check("R7 flag during soft-start", ovl_flag, 0);
        oc_det = '0; ss_done = '1;
        step();
        check("R7 flag after soft-start", ovl_flag, 0);

        // R2..R5: sweep overcurrent position in probe window (-1 = none)
        for (int p = -1; p < ONN; p++) begin
            trigger0();
            count_off(n);
            check("R2 off window length", n, OFFN);
            count_on(p, n);
            check("R3 probe window length", n, ONN);
            if (p >= 0) begin
                check("R4 retry gate", out_en[0], 0);
                check("R4 retry flag", ovl_flag[0], 1);
                count_off(n);
                check("R2 retry off length", n, OFFN);
                count_on(-1, n);
                check("R3 retry probe length", n, ONN);
            end
            check("R5 recovered gate", out_en[0], 1);
            check("R5 recovered flag", ovl_flag[0], 0);
        end

        // R2: no ticks, no progress; overcurrent during off ignored
        ms_tick = 0;
        trigger0();
        hi = 0;
        for (int k = 0; k < 40; k++) begin
            oc_det[0] = k[0];
            step();
            if (out_en[0]) hi++;
        end
        oc_det[0] = 0;
        check("R2 stall without ticks", hi, 0);
        ms_tick = 1;
        count_off(n);
        check("R2 off length after stall", n, OFFN);
        count_on(-1, n);
        check("R5 recovery after stall", ovl_flag[0], 0);

        // R6: clamp-report mode on channel 1, pattern sweep
        static_mode[1] = 1;
        step();
        check("R9 mode change ch1 flag", ovl_flag[1], 0);
        for (int k = 0; k < 16; k++) begin
            exp_flag = ((k * 5) % 3 == 0) ? 1 : 0;
            oc_det[1] = exp_flag[0];
            step();
            check("R6 static flag follows", ovl_flag[1], exp_flag);
            check("R6 static gate on", out_en[1], 1);
        end
        oc_det[1] = 0;

        // R9: mode change in middle of off window
        trigger0();
        repeat (2) step();
        static_mode[0] = 1; oc_det[0] = 1;
        step();
        check("R9 mode change gate", out_en[0], 1);
        check("R9 mode change flag", ovl_flag[0], 0);
        step();
        check("R9 re-evaluated static flag", ovl_flag[0], 1);
        check("R9 re-evaluated static gate", out_en[0], 1);
        oc_det[0] = 0; static_mode[0] = 0;
        step();
        check("R9 back to retry flag", ovl_flag[0], 0);
        step();
        check("R9 retry mode normal gate", out_en[0], 1);

        // R8: disable in off window
        trigger0();
        step();
        ch_en[0] = 0;
        step();
        check("R8 disabled gate", out_en[0], 0);
        check("R8 disabled flag", ovl_flag[0], 0);
        check("R10 ch1 unaffected", out_en[1], 1);
        ch_en[0] = 1;
        step();
        check("R8 re-enabled gate", out_en[0], 1);
        check("R8 re-enabled flag", ovl_flag[0], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule